// File: doc/BRIEF.md
# Coherence Manager Request Serializer

This block sits between a set of CPU request ports and a shared memory-side command port. It serves one transaction at a time. A round-robin arbiter picks one waiting port. Its request is either coherent or noncoherent.

For a coherent request, the block broadcasts a one-cycle intervention to every port except the initiator. It then waits until each peer has returned exactly one response giving its line state. If a peer reports that it held the line dirty on a read, the block sends that peer's data to the requester and also writes it to memory. If no peer reports dirty data, the block reads the line from memory and returns the memory data to the requester. Writebacks pass the requester's evicted line to memory. Upgrades and invalidates finish with a data-less acknowledgement.

Noncoherent requests skip the broadcast and go straight to memory as plain reads or writes. Every transaction ends with a one-cycle done pulse to its requester. Only after that pulse can the next request be granted.

Top module: `coh_req_serializer`

## Requirements
- R1: While reset is held, and after it is released with no request pending, req_grant, ivn_valid, mem_cmd_valid and done_valid are all 0.
- R2: Grants are round-robin. The search starts at the port after the one last granted, and at port 0 after reset. req_grant is a one-cycle one-hot pulse naming the accepted port.
- R3: No further grant is issued until done_valid has pulsed for the transaction in flight. done_valid is never high two cycles in a row.
- R4: A coherent request raises ivn_valid for exactly one cycle. ivn_valid has every bit set except the initiator's, and ivn_op and ivn_addr carry the request's op code and address. The op codes are: read-shared 0, read-for-ownership 1, upgrade 2, writeback 3, invalidate 4, noncoherent read 5, noncoherent write 6.
- R5: A coherent request issues no memory command and no done pulse until every peer in the broadcast has returned a response. Responses may arrive in any cycle order.
- R6: On a read-shared or read-for-ownership request, if a peer responds with rsp_dirty=1, the block issues a memory write of that peer's data to the request address. In the same cycle it pulses done with done_has_data=1 and done_data set to the peer's data.
- R7: On a read-shared or read-for-ownership request where no peer is dirty, the block issues a memory read with mem_cmd_wdata=0. The cycle after mem_rd_valid, it pulses done with done_has_data=1 and done_data equal to mem_rd_data.
- R8: Upgrade and invalidate requests finish with done_has_data=0 and done_data=0 once all peers have responded. They issue no memory command.
- R9: A writeback request issues a memory write of the requester's req_wdata after all responses are in. Dirty data reported by any peer is ignored. done_has_data is 0.
- R10: Noncoherent read and write requests raise no intervention. A noncoherent write issues a memory write of req_wdata and finishes with no data. A noncoherent read finishes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request pending per port, held until granted |
| req_op | input | NPORT*3 | Op code per port |
| req_addr | input | NPORT*AW | Line address per port |
| req_wdata | input | NPORT*DW | Line data per port (writes and writebacks) |
| req_grant | output | NPORT | One-hot acceptance pulse |
| done_valid | output | 1 | Completion pulse to the requester |
| done_port | output | $clog2(NPORT) | Index of the completing port |
| done_has_data | output | 1 | Completion carries a refill |
| done_data | output | DW | Refill data |
| ivn_valid | output | NPORT | Intervention pulse per peer |
| ivn_op | output | 3 | Op code of the intervention |
| ivn_addr | output | AW | Address of the intervention |
| rsp_valid | input | NPORT | Peer response strobe |
| rsp_dirty | input | NPORT | Peer held the line modified and supplies data |
| rsp_data | input | NPORT*DW | Data supplied by each peer |
| mem_cmd_valid | output | 1 | Memory command pulse |
| mem_cmd_write | output | 1 | 1 for write, 0 for read |
| mem_cmd_addr | output | AW | Memory command address |
| mem_cmd_wdata | output | DW | Memory write data |
| mem_rd_valid | input | 1 | Memory read data strobe |
| mem_rd_data | input | DW | Memory read data |

## Verification
The assertions assume a requester keeps req_valid high until its grant appears and then lowers it. They also assume that each peer answers an intervention exactly once, that the memory returns exactly one mem_rd_valid per read command, and that no such read data arrives unrequested.

The stimulus models each peer and the memory as responders that only act after an intervention or a read command has been seen. Each peer answers after its own configurable delay, which produces staggered and reordered response arrivals. The requesters clear their request bit once they count their own grant.

// File: rtl/crs_pkg.sv
package crs_pkg;

  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_RD_SHR = 3'd0;
  localparam logic [OPW-1:0] OP_RD_OWN = 3'd1;
  localparam logic [OPW-1:0] OP_UPGR   = 3'd2;
  localparam logic [OPW-1:0] OP_WBACK  = 3'd3;
  localparam logic [OPW-1:0] OP_INVAL  = 3'd4;
  localparam logic [OPW-1:0] OP_NC_RD  = 3'd5;
  localparam logic [OPW-1:0] OP_NC_WR  = 3'd6;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_COLLECT  = 2'd1,
    ST_WAIT_MEM = 2'd2
  } crs_state_e;

  function automatic logic op_is_coherent(input logic [OPW-1:0] op);
    return (op <= OP_INVAL);
  endfunction

endpackage

// File: rtl/crs_rr_arbiter.sv
module crs_rr_arbiter #(
  parameter int NPORT = 4,
  parameter int IW    = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req,
  input  logic             take,
  output logic             gnt_any,
  output logic [IW-1:0]    gnt_idx
);

  logic [IW-1:0] ptr_q;
  int unsigned   pos;

  // Scan from the pointer upward; reverse loop lets the nearest requester win.
  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    pos     = 0;
    for (int k = NPORT - 1; k >= 0; k--) begin
      pos = (int'(ptr_q) + k) % NPORT;
      if (req[pos]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(pos);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (take) begin
      if (gnt_idx == IW'(NPORT - 1)) ptr_q <= '0;
      else                           ptr_q <= gnt_idx + 1'b1;
    end
  end

  AST_ARB_IDLE_NO_PICK: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> !gnt_any); // R2

endmodule

// File: rtl/crs_resp_collector.sv
module crs_resp_collector #(
  parameter int NPORT = 4,
  parameter int DW    = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arm,
  input  logic [NPORT-1:0]    arm_mask,
  input  logic [NPORT-1:0]    rsp_valid,
  input  logic [NPORT-1:0]    rsp_dirty,
  input  logic [NPORT*DW-1:0] rsp_data,
  output logic [NPORT-1:0]    pend,
  output logic                dirty_hit,
  output logic [DW-1:0]       dirty_data
);

  logic [NPORT-1:0] pend_q;
  logic             hit_q;
  logic [DW-1:0]    data_q;
  logic             new_hit;
  logic [DW-1:0]    new_data;

  // Lowest-numbered dirty responder of this cycle, among those still pending.
  always_comb begin
    new_hit  = 1'b0;
    new_data = '0;
    for (int k = NPORT - 1; k >= 0; k--) begin
      if (rsp_valid[k] && pend_q[k] && rsp_dirty[k]) begin
        new_hit  = 1'b1;
        new_data = rsp_data[k*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      hit_q  <= 1'b0;
      data_q <= '0;
    end else if (arm) begin
      pend_q <= arm_mask;
      hit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_q & ~rsp_valid;
      if (!hit_q && new_hit) begin
        hit_q  <= 1'b1;
        data_q <= new_data;
      end
    end
  end

  assign pend       = pend_q;
  assign dirty_hit  = hit_q;
  assign dirty_data = data_q;

  AST_PEND_NEVER_GROWS: assert property (@(posedge clk) disable iff (rst)
    !arm |=> ((pend_q & ~$past(pend_q)) == '0)); // R5

endmodule

// File: rtl/coh_req_serializer.sv
module coh_req_serializer
  import crs_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int IW    = $clog2(NPORT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORT-1:0]     req_valid,
  input  logic [NPORT*3-1:0]   req_op,
  input  logic [NPORT*AW-1:0]  req_addr,
  input  logic [NPORT*DW-1:0]  req_wdata,
  output logic [NPORT-1:0]     req_grant,
  output logic                 done_valid,
  output logic [IW-1:0]        done_port,
  output logic                 done_has_data,
  output logic [DW-1:0]        done_data,
  output logic [NPORT-1:0]     ivn_valid,
  output logic [2:0]           ivn_op,
  output logic [AW-1:0]        ivn_addr,
  input  logic [NPORT-1:0]     rsp_valid,
  input  logic [NPORT-1:0]     rsp_dirty,
  input  logic [NPORT*DW-1:0]  rsp_data,
  output logic                 mem_cmd_valid,
  output logic                 mem_cmd_write,
  output logic [AW-1:0]        mem_cmd_addr,
  output logic [DW-1:0]        mem_cmd_wdata,
  input  logic                 mem_rd_valid,
  input  logic [DW-1:0]        mem_rd_data
);

  localparam logic [NPORT-1:0] ONE = {{(NPORT-1){1'b0}}, 1'b1};

  crs_state_e         state_q;
  logic [IW-1:0]      cur_port_q;
  logic [OPW-1:0]     cur_op_q;
  logic [AW-1:0]      cur_addr_q;
  logic [DW-1:0]      cur_wdata_q;

  logic [NPORT-1:0]   grant_q, ivn_valid_q;
  logic [OPW-1:0]     ivn_op_q;
  logic [AW-1:0]      ivn_addr_q;
  logic               mem_v_q, mem_w_q;
  logic [AW-1:0]      mem_a_q;
  logic [DW-1:0]      mem_d_q;
  logic               done_v_q, done_h_q;
  logic [DW-1:0]      done_d_q;

  logic               gnt_any;
  logic [IW-1:0]      gnt_idx;
  logic [NPORT-1:0]   gnt_oh;
  logic [OPW-1:0]     sel_op;
  logic               sel_coh;
  logic               accept;
  logic [NPORT-1:0]   pend;
  logic               dirty_hit;
  logic [DW-1:0]      dirty_data;

  assign accept  = (state_q == ST_IDLE) && gnt_any;
  assign gnt_oh  = ONE << gnt_idx;
  assign sel_op  = req_op[gnt_idx*OPW +: OPW];
  assign sel_coh = op_is_coherent(sel_op);

  crs_rr_arbiter #(.NPORT(NPORT), .IW(IW)) arb_i (
    .clk     (clk),
    .rst     (rst),
    .req     (req_valid),
    .take    (accept),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  // Noncoherent requests arm with an empty mask so they finish on the next edge.
  crs_resp_collector #(.NPORT(NPORT), .DW(DW)) col_i (
    .clk        (clk),
    .rst        (rst),
    .arm        (accept),
    .arm_mask   (sel_coh ? ~gnt_oh : '0),
    .rsp_valid  (rsp_valid),
    .rsp_dirty  (rsp_dirty),
    .rsp_data   (rsp_data),
    .pend       (pend),
    .dirty_hit  (dirty_hit),
    .dirty_data (dirty_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cur_port_q  <= '0;
      cur_op_q    <= '0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      grant_q     <= '0;
      ivn_valid_q <= '0;
      ivn_op_q    <= '0;
      ivn_addr_q  <= '0;
      mem_v_q     <= 1'b0;
      mem_w_q     <= 1'b0;
      mem_a_q     <= '0;
      mem_d_q     <= '0;
      done_v_q    <= 1'b0;
      done_h_q    <= 1'b0;
      done_d_q    <= '0;
    end else begin
      grant_q     <= '0;
      ivn_valid_q <= '0;
      mem_v_q     <= 1'b0;
      done_v_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (gnt_any) begin
            grant_q     <= gnt_oh;
            cur_port_q  <= gnt_idx;
            cur_op_q    <= sel_op;
            cur_addr_q  <= req_addr[gnt_idx*AW +: AW];
            cur_wdata_q <= req_wdata[gnt_idx*DW +: DW];
            if (sel_coh) begin
              ivn_valid_q <= ~gnt_oh;
              ivn_op_q    <= sel_op;
              ivn_addr_q  <= req_addr[gnt_idx*AW +: AW];
            end
            state_q <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (pend == '0) begin
            mem_a_q <= cur_addr_q;
            if ((cur_op_q == OP_RD_SHR) || (cur_op_q == OP_RD_OWN)) begin
              if (dirty_hit) begin
                mem_v_q  <= 1'b1;
                mem_w_q  <= 1'b1;
                mem_d_q  <= dirty_data;
                done_v_q <= 1'b1;
                done_h_q <= 1'b1;
                done_d_q <= dirty_data;
                state_q  <= ST_IDLE;
              end else begin
                mem_v_q <= 1'b1;
                mem_w_q <= 1'b0;
                mem_d_q <= '0;
                state_q <= ST_WAIT_MEM;
              end
            end else if (cur_op_q == OP_NC_RD) begin
              mem_v_q <= 1'b1;
              mem_w_q <= 1'b0;
              mem_d_q <= '0;
              state_q <= ST_WAIT_MEM;
            end else if ((cur_op_q == OP_WBACK) || (cur_op_q == OP_NC_WR)) begin
              mem_v_q  <= 1'b1;
              mem_w_q  <= 1'b1;
              mem_d_q  <= cur_wdata_q;
              done_v_q <= 1'b1;
              done_h_q <= 1'b0;
              done_d_q <= '0;
              state_q  <= ST_IDLE;
            end else begin
              done_v_q <= 1'b1;
              done_h_q <= 1'b0;
              done_d_q <= '0;
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_WAIT_MEM: begin
          if (mem_rd_valid) begin
            done_v_q <= 1'b1;
            done_h_q <= 1'b1;
            done_d_q <= mem_rd_data;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_grant     = grant_q;
  assign ivn_valid     = ivn_valid_q;
  assign ivn_op        = ivn_op_q;
  assign ivn_addr      = ivn_addr_q;
  assign mem_cmd_valid = mem_v_q;
  assign mem_cmd_write = mem_w_q;
  assign mem_cmd_addr  = mem_a_q;
  assign mem_cmd_wdata = mem_d_q;
  assign done_valid    = done_v_q;
  assign done_port     = cur_port_q;
  assign done_has_data = done_h_q;
  assign done_data     = done_d_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_grant)); // R2

  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (req_grant == '0)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R3

  AST_IVN_PEER_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ivn_valid != '0) |-> ($countones(ivn_valid) == NPORT - 1)); // R4

  AST_IVN_SKIPS_INIT: assert property (@(posedge clk) disable iff (rst)
    (ivn_valid != '0) |-> ((ivn_valid & req_grant) == '0)); // R4

  AST_WAIT_ALL_RESP: assert property (@(posedge clk) disable iff (rst)
    (done_valid || mem_cmd_valid) |-> (pend == '0)); // R5

  AST_NO_IVN_WITH_MEM: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_valid |-> (ivn_valid == '0)); // R10

endmodule

// File: tb/coh_req_serializer_tb_top.sv
`timescale 1ns/1ps
module coh_req_serializer_tb_top;

  localparam int NPORT = 4;
  localparam int AW    = 32;
  localparam int DW    = 64;
  localparam int IW    = $clog2(NPORT);

  typedef struct packed {
    logic [NPORT-1:0] mask;
    logic [2:0]       op;
    logic [AW-1:0]    addr;
  } ivn_t;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } mem_t;

  typedef struct packed {
    logic [IW-1:0] port;
    logic          has;
    logic [DW-1:0] data;
  } done_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NPORT-1:0]    req_valid;
  logic [NPORT*3-1:0]  req_op    = '0;
  logic [NPORT*AW-1:0] req_addr  = '0;
  logic [NPORT*DW-1:0] req_wdata = '0;
  logic [NPORT-1:0]    req_grant;
  logic                done_valid, done_has_data;
  logic [IW-1:0]       done_port;
  logic [DW-1:0]       done_data;
  logic [NPORT-1:0]    ivn_valid;
  logic [2:0]          ivn_op;
  logic [AW-1:0]       ivn_addr;
  logic [NPORT-1:0]    rsp_valid = '0;
  logic [NPORT-1:0]    rsp_dirty = '0;
  logic [NPORT*DW-1:0] rsp_data  = '0;
  logic                mem_cmd_valid, mem_cmd_write;
  logic [AW-1:0]       mem_cmd_addr;
  logic [DW-1:0]       mem_cmd_wdata;
  logic                mem_rd_valid = 1'b0;
  logic [DW-1:0]       mem_rd_data  = '0;

  coh_req_serializer #(.NPORT(NPORT), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_grant(req_grant),
    .done_valid(done_valid), .done_port(done_port), .done_has_data(done_has_data),
    .done_data(done_data),
    .ivn_valid(ivn_valid), .ivn_op(ivn_op), .ivn_addr(ivn_addr),
    .rsp_valid(rsp_valid), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  int checks = 0;
  int fails  = 0;

  int post_cnt [NPORT];
  int gnt_cnt  [NPORT];
  int cfg_delay[NPORT];
  logic          cfg_dirty[NPORT];
  logic [DW-1:0] cfg_data [NPORT];
  int  rcnt [NPORT];
  int  rsp_out = 0;
  int  mcnt = 0;
  logic [AW-1:0] maddr = '0;
  logic busy = 1'b0;

  int    exp_gnt [$];
  ivn_t  exp_ivn [$];
  mem_t  exp_mem [$];
  string mem_tag [$];
  done_t exp_done[$];
  string done_tag[$];

  initial begin
    for (int p = 0; p < NPORT; p++) begin
      post_cnt[p] = 0; gnt_cnt[p] = 0; rcnt[p] = 0;
      cfg_delay[p] = 1; cfg_dirty[p] = 1'b0; cfg_data[p] = '0;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) req_valid[p] = (post_cnt[p] != gnt_cnt[p]);
  end

  function automatic logic [DW-1:0] mem_img(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic post(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    req_op[p*3 +: 3]     = op;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
    post_cnt[p]++;
  endtask

  task automatic set_peer(input int p, input int dly, input logic dirty, input logic [DW-1:0] d);
    cfg_delay[p] = dly; cfg_dirty[p] = dirty; cfg_data[p] = d;
  endtask

  task automatic push_ivn(input int init, input logic [2:0] op, input logic [AW-1:0] a);
    ivn_t e;
    e.mask = ~(NPORT'(1) << init);
    e.op   = op;
    e.addr = a;
    exp_ivn.push_back(e);
  endtask

  task automatic push_mem(input string tag, input logic wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
    mem_t e;
    e.wr = wr; e.addr = a; e.data = d;
    exp_mem.push_back(e);
    mem_tag.push_back(tag);
  endtask

  task automatic push_done(input string tag, input int p, input logic h, input logic [DW-1:0] d);
    done_t e;
    e.port = IW'(p); e.has = h; e.data = d;
    exp_done.push_back(e);
    done_tag.push_back(tag);
  endtask

  task automatic wait_quiet();
    int n = 0;
    while (((exp_gnt.size() + exp_ivn.size() + exp_mem.size() + exp_done.size()) != 0 || busy)
           && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) begin
      checks++; fails++;
      $display("FAIL stall: expected items left gnt=%0d ivn=%0d mem=%0d done=%0d expected=0",
               exp_gnt.size(), exp_ivn.size(), exp_mem.size(), exp_done.size());
    end
    repeat (3) @(negedge clk);
  endtask

  // Peer and memory responders
  always @(negedge clk) begin
    rsp_valid    = '0;
    rsp_dirty    = '0;
    mem_rd_valid = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (rcnt[p] > 0) begin
        rcnt[p]--;
        if (rcnt[p] == 0) begin
          rsp_valid[p] = 1'b1;
          rsp_dirty[p] = cfg_dirty[p];
          rsp_data[p*DW +: DW] = cfg_data[p];
          rsp_out--;
        end
      end
    end
    if (!rst && ivn_valid != '0) begin
      for (int p = 0; p < NPORT; p++) begin
        if (ivn_valid[p]) begin
          rcnt[p] = cfg_delay[p];
          rsp_out++;
        end
      end
    end
    if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem_img(maddr);
      end
    end
    if (!rst && mem_cmd_valid && !mem_cmd_write) begin
      mcnt  = 3;
      maddr = mem_cmd_addr;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (req_grant != '0) begin
        if (busy) begin
          checks++; fails++;
          $display("FAIL R3 grant during busy: actual=%b expected=0", req_grant);
        end
        busy = 1'b1;
        for (int p = 0; p < NPORT; p++) if (req_grant[p]) gnt_cnt[p]++;
        if (exp_gnt.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected grant actual=%b expected=none", req_grant);
        end else begin
          chk("R2 grant order", 160'(req_grant), 160'(NPORT'(1) << exp_gnt.pop_front()));
        end
      end
      if (ivn_valid != '0) begin
        if (exp_ivn.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4/R10 unexpected intervention actual=%b expected=none", ivn_valid);
        end else begin
          chk("R4 intervention", 160'({ivn_valid, ivn_op, ivn_addr}), 160'(exp_ivn.pop_front()));
        end
      end
      if (mem_cmd_valid) begin
        chk("R5 mem cmd before all responses", 160'(rsp_out), 160'(0));
        if (exp_mem.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 unexpected mem cmd actual=%h expected=none", mem_cmd_addr);
        end else begin
          chk(mem_tag.pop_front(), 160'({mem_cmd_write, mem_cmd_addr, mem_cmd_wdata}),
              160'(exp_mem.pop_front()));
        end
      end
      if (done_valid) begin
        chk("R5 done before all responses", 160'(rsp_out), 160'(0));
        if (exp_done.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3 unexpected done actual=%0d expected=none", done_port);
        end else begin
          chk(done_tag.pop_front(), 160'({done_port, done_has_data, done_data}),
              160'(exp_done.pop_front()));
        end
        busy = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 grant in reset", 160'(req_grant), 160'(0));
    chk("R1 ivn in reset",   160'(ivn_valid), 160'(0));
    chk("R1 mem in reset",   160'(mem_cmd_valid), 160'(0));
    chk("R1 done in reset",  160'(done_valid), 160'(0));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", 160'({req_grant, ivn_valid, mem_cmd_valid, done_valid}), 160'(0));

    // R10: noncoherent write on port 1
    exp_gnt.push_back(1);
    push_mem("R10 nc write cmd", 1'b1, 32'h0000_1000, 64'h1111_2222_3333_4444);
    push_done("R10 nc write done", 1, 1'b0, '0);
    post(1, 3'd6, 32'h0000_1000, 64'h1111_2222_3333_4444);
    wait_quiet();

    // R10/R7: noncoherent read on port 2
    exp_gnt.push_back(2);
    push_mem("R10 nc read cmd", 1'b0, 32'h0000_2040, '0);
    push_done("R7 nc read refill", 2, 1'b1, mem_img(32'h0000_2040));
    post(2, 3'd5, 32'h0000_2040, 64'hDEAD);
    wait_quiet();

    // R4/R5/R7: read-shared from port 0, all peers clean, staggered responses
    set_peer(1, 1, 1'b0, 64'h0); set_peer(2, 4, 1'b0, 64'h0); set_peer(3, 2, 1'b0, 64'h0);
    exp_gnt.push_back(0);
    push_ivn(0, 3'd0, 32'h0000_3000);
    push_mem("R7 miss mem read", 1'b0, 32'h0000_3000, '0);
    push_done("R7 miss refill", 0, 1'b1, mem_img(32'h0000_3000));
    post(0, 3'd0, 32'h0000_3000, '0);
    wait_quiet();

    // R6: read-for-ownership from port 3, peer 1 dirty and last to answer
    set_peer(0, 2, 1'b0, 64'h0); set_peer(1, 5, 1'b1, 64'hABCD_0123_4567_89EF);
    set_peer(2, 1, 1'b0, 64'h0);
    exp_gnt.push_back(3);
    push_ivn(3, 3'd1, 32'h0000_4080);
    push_mem("R6 dirty writeback to memory", 1'b1, 32'h0000_4080, 64'hABCD_0123_4567_89EF);
    push_done("R6 dirty forward refill", 3, 1'b1, 64'hABCD_0123_4567_89EF);
    post(3, 3'd1, 32'h0000_4080, '0);
    wait_quiet();

    // R8: upgrade from port 2
    set_peer(0, 3, 1'b0, 64'h0); set_peer(1, 1, 1'b0, 64'h0); set_peer(3, 2, 1'b0, 64'h0);
    exp_gnt.push_back(2);
    push_ivn(2, 3'd2, 32'h0000_50C0);
    push_done("R8 upgrade ack", 2, 1'b0, '0);
    post(2, 3'd2, 32'h0000_50C0, 64'h77);
    wait_quiet();

    // R8: invalidate from port 1, a peer wrongly reports dirty: still no data
    set_peer(0, 2, 1'b1, 64'h9999); set_peer(2, 3, 1'b0, 64'h0); set_peer(3, 1, 1'b0, 64'h0);
    exp_gnt.push_back(1);
    push_ivn(1, 3'd4, 32'h0000_6000);
    push_done("R8 invalidate ack", 1, 1'b0, '0);
    post(1, 3'd4, 32'h0000_6000, '0);
    wait_quiet();

    // R9: writeback from port 0, peer 2 reports dirty data which must be ignored
    set_peer(1, 2, 1'b0, 64'h0); set_peer(2, 1, 1'b1, 64'hBAD0_BAD0); set_peer(3, 3, 1'b0, 64'h0);
    exp_gnt.push_back(0);
    push_ivn(0, 3'd3, 32'h0000_7100);
    push_mem("R9 writeback data", 1'b1, 32'h0000_7100, 64'h0F0F_F0F0_5555_AAAA);
    push_done("R9 writeback done", 0, 1'b0, '0);
    post(0, 3'd3, 32'h0000_7100, 64'h0F0F_F0F0_5555_AAAA);
    wait_quiet();

    // R2: simultaneous requests on 0,2,3; pointer sits at 1 -> order 2,3,0
    exp_gnt.push_back(2); exp_gnt.push_back(3); exp_gnt.push_back(0);
    push_mem("R2 rr first",  1'b1, 32'h0000_8200, 64'h22);
    push_done("R2 rr first done", 2, 1'b0, '0);
    push_mem("R2 rr second", 1'b1, 32'h0000_8300, 64'h33);
    push_done("R2 rr second done", 3, 1'b0, '0);
    push_mem("R2 rr third",  1'b1, 32'h0000_8000, 64'h00);
    push_done("R2 rr third done", 0, 1'b0, '0);
    post(0, 3'd6, 32'h0000_8000, 64'h00);
    post(2, 3'd6, 32'h0000_8200, 64'h22);
    post(3, 3'd6, 32'h0000_8300, 64'h33);
    wait_quiet();

    // R3: requests arriving while a slow coherent read is in flight wait for its done
    set_peer(0, 6, 1'b0, 64'h0); set_peer(2, 7, 1'b0, 64'h0); set_peer(3, 6, 1'b0, 64'h0);
    exp_gnt.push_back(1); exp_gnt.push_back(3); exp_gnt.push_back(0);
    push_ivn(1, 3'd0, 32'h0000_9000);
    push_mem("R3 inflight read cmd", 1'b0, 32'h0000_9000, '0);
    push_done("R3 inflight refill", 1, 1'b1, mem_img(32'h0000_9000));
    push_mem("R3 queued write port 3", 1'b1, 32'h0000_9300, 64'h3333);
    push_done("R3 queued done port 3", 3, 1'b0, '0);
    push_mem("R3 queued write port 0", 1'b1, 32'h0000_9030, 64'h0303);
    push_done("R3 queued done port 0", 0, 1'b0, '0);
    post(1, 3'd0, 32'h0000_9000, '0);
    repeat (4) @(negedge clk);
    post(0, 3'd6, 32'h0000_9030, 64'h0303);
    post(3, 3'd6, 32'h0000_9300, 64'h3333);
    wait_quiet();

    chk("R1 idle at end", 160'({req_grant, ivn_valid, mem_cmd_valid, done_valid}), 160'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule